// File: doc/BRIEF.md
# Edge-Latched Byte Memory Slave

This block models a byte-wide memory that sits behind an asynchronous, active-low pin interface, and it is built to run inside a chip on one fast system clock. A host toggles a select line, a write strobe and an output-gate line, presents a 13-bit address and moves bytes over a data bus. The bus is split into an input byte, an output byte and a drive-enable flag. Every pin is brought into the clock domain through a synchronizer. The block keeps 8192 bytes of storage and performs the reads and writes the pins ask for.

The address is taken only at the moment the select line falls, and it is held until the next fall. An address that moves while select stays low has no effect. Every new access therefore needs select to go high for a while (the precharge interval) and then fall again. While select is low, a low write strobe makes the access a write and a high write strobe makes it a read. The output-gate line does nothing except control whether the data bus is driven.

Top module: `cel_byte_mem`

## Requirements
- R1: While reset is held, and right after it is released, the bus drive enable `dq_oe_o` is 0 and the held access address is zero.
- R2: The address present on `pin_addr_i` when a falling edge of `sel_n_i` is detected is captured. A read in that access returns the byte stored at the captured address.
- R3: Changes on `pin_addr_i` while `sel_n_i` stays low are ignored until the next falling edge of `sel_n_i`.
- R4: While `sel_n_i` is high, the block is in standby. The bus is not driven, and pulsing `wen_n_i` low with data on `dq_i` stores nothing.
- R5: With `sel_n_i` low and `wen_n_i` low, the byte on `dq_i` is written to the captured address. The write is committed when `wen_n_i` or `sel_n_i` rises, whichever comes first, and it stores the last byte sampled while `wen_n_i` was low.
- R6: If `wen_n_i` is already low when `sel_n_i` falls, the write begins with that access and is committed when `sel_n_i` rises.
- R7: `oen_n_i` high keeps `dq_oe_o` at 0 but does not stop a write from being stored.
- R8: During a write, `dq_oe_o` stays 0 even when `oen_n_i` is low.
- R9: With `sel_n_i` low, `wen_n_i` high and `oen_n_i` low, `dq_oe_o` is 1 and `dq_o` carries the byte stored at the captured address.
- R10: All 8192 locations are distinct. Address 0 and address 8191 hold independent bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_addr_i | input | 13 | Address pins, captured on a falling edge of select |
| dq_i | input | 8 | Data arriving from the bus |
| dq_o | output | 8 | Data driven onto the bus during a read |
| dq_oe_o | output | 1 | Bus drive enable; 0 means tri-stated |
| sel_n_i | input | 1 | Active-low select |
| wen_n_i | input | 1 | Active-low write strobe |
| oen_n_i | input | 1 | Active-low output gate, controls the drivers only |

## Verification
The hardest case to reach from the pins is a write that changes its data byte while the strobe is low and then ends on a select rise rather than a strobe rise. In the same access the address pins are scrambled after the capture. Only a later read of the original address shows whether the last byte went to the captured location. The stimulus gets there by mixing random write shapes: strobe low before or after the select fall, ending on strobe or on select, with or without address scrambling. A byte-level model in the bench follows every committed write. Directed standby pulses and writes with the output gate high then confirm that nothing is stored outside a selected access and that the gate never blocks a write.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  localparam int unsigned CBM_ADDR_W      = 13;
  localparam int unsigned CBM_DATA_W      = 8;
  localparam int unsigned CBM_SYNC_STAGES = 2;

  // synchronized control pins, all active low
  typedef struct packed {
    logic sel_n;
    logic wen_n;
    logic oen_n;
  } cbm_ctl_t;

  typedef enum logic [1:0] {
    PH_STANDBY = 2'd0,
    PH_READ    = 2'd1,
    PH_WRITE   = 2'd2
  } cbm_phase_t;

endpackage

// File: rtl/cbm_sync.sv
module cbm_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {STAGES{RST_VAL}};
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/cbm_store.sv
module cbm_store #(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      mem_q[addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[addr_i];

  // a committed byte lands at the address it was committed to
  assert_commit_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (mem_q[$past(addr_i)] == $past(wr_data_i)));

endmodule

// File: rtl/cbm_ctrl.sv
module cbm_ctrl
  import cbm_pkg::*;
#(
  parameter int unsigned AW = CBM_ADDR_W,
  parameter int unsigned DW = CBM_DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cbm_ctl_t      ctl_s_i,
  input  logic [AW-1:0] addr_s_i,
  input  logic [DW-1:0] dq_s_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] acc_addr_o,
  output logic          wr_en_o,
  output logic [DW-1:0] wr_data_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);

  logic          sel_prev_q;
  logic [AW-1:0] addr_lat_q;
  logic          pend_q, pend_d;
  logic [DW-1:0] wdat_q, wdat_d;
  logic          wdat_en;
  logic          drive_q, drive_d;
  logic [DW-1:0] dout_q;
  logic          sel_fall;
  logic          commit;
  cbm_phase_t    phase;

  // ---------------- next-state logic ----------------
  always_comb begin
    sel_fall = !ctl_s_i.sel_n && sel_prev_q;

    if (ctl_s_i.sel_n)        phase = PH_STANDBY;
    else if (!ctl_s_i.wen_n)  phase = PH_WRITE;
    else                      phase = PH_READ;

    // a pending write closes when either strobe returns high
    commit  = pend_q && (phase != PH_WRITE);
    pend_d  = pend_q;
    wdat_en = 1'b0;
    wdat_d  = wdat_q;
    if (commit) begin
      pend_d = 1'b0;
    end
    if (phase == PH_WRITE) begin
      pend_d  = 1'b1;
      wdat_en = 1'b1;
      wdat_d  = dq_s_i;
    end

    drive_d = (phase == PH_READ) && !sel_prev_q &&
              !ctl_s_i.oen_n && !pend_q;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev_q <= 1'b1;
      pend_q     <= 1'b0;
      drive_q    <= 1'b0;
    end else begin
      sel_prev_q <= ctl_s_i.sel_n;
      pend_q     <= pend_d;
      drive_q    <= drive_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lat_q <= '0;
    end else if (sel_fall) begin
      addr_lat_q <= addr_s_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdat_q <= '0;
    end else if (wdat_en) begin
      wdat_q <= wdat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
    end else if (drive_d) begin
      dout_q <= rd_data_i;
    end
  end

  assign acc_addr_o = addr_lat_q;
  assign wr_en_o    = commit;
  assign wr_data_o  = wdat_q;
  assign dq_o       = dout_q;
  assign dq_oe_o    = drive_q;

  // ---------------- assertions ----------------
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (!dq_oe_o && (acc_addr_o == '0)));

  assert_fall_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fall |=> (acc_addr_o == $past(addr_s_i)));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_s_i.sel_n && !sel_prev_q) |=> $stable(acc_addr_o));

  assert_standby_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_s_i.sel_n |=> !dq_oe_o);

  assert_standby_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_s_i.sel_n && sel_prev_q && $past(ctl_s_i.sel_n)) |-> !wr_en_o);

  assert_gate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_s_i.oen_n |=> !dq_oe_o);

  assert_no_drive_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_s_i.sel_n && !ctl_s_i.wen_n) |=> !dq_oe_o);

  assert_write_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);

endmodule

// File: rtl/cel_byte_mem.sv
module cel_byte_mem
  import cbm_pkg::*;
#(
  parameter int unsigned ADDR_W      = CBM_ADDR_W,
  parameter int unsigned DATA_W      = CBM_DATA_W,
  parameter int unsigned SYNC_STAGES = CBM_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pin_addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic              sel_n_i,
  input  logic              wen_n_i,
  input  logic              oen_n_i
);

  localparam int unsigned CTL_W = $bits(cbm_ctl_t);

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [CTL_W-1:0]  ctl_raw;
  cbm_ctl_t          ctl_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] dq_s;
  logic [ADDR_W-1:0] acc_addr;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;

  // reset asserts at once, leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  cbm_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTL_W{1'b1}})) u_sync_ctl (
    .clk(clk), .rst_n(rst_int_n),
    .d_i({sel_n_i, wen_n_i, oen_n_i}), .q_o(ctl_raw)
  );
  assign ctl_s = cbm_ctl_t'(ctl_raw);

  cbm_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_addr (
    .clk(clk), .rst_n(rst_int_n), .d_i(pin_addr_i), .q_o(addr_s)
  );

  cbm_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_dq (
    .clk(clk), .rst_n(rst_int_n), .d_i(dq_i), .q_o(dq_s)
  );

  cbm_ctrl #(.AW(ADDR_W), .DW(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .ctl_s_i(ctl_s), .addr_s_i(addr_s), .dq_s_i(dq_s), .rd_data_i(rd_data),
    .acc_addr_o(acc_addr), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  cbm_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en_i(wr_en), .addr_i(acc_addr), .wr_data_i(wr_data), .rd_data_o(rd_data)
  );

endmodule

// File: tb/cel_byte_mem_bench.sv
module cel_byte_mem_bench;

  localparam int AW     = 13;
  localparam int DW     = 8;
  localparam int SETTLE = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] pin_addr = '0;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic          dq_oe;
  logic          sel_n = 1'b1;
  logic          wen_n = 1'b1;
  logic          oen_n = 1'b1;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [int];

  always #5 clk = ~clk;

  cel_byte_mem u_cel_byte_mem (
    .clk(clk), .rst_n(rst_n), .pin_addr_i(pin_addr), .dq_i(dq_i),
    .dq_o(dq_o), .dq_oe_o(dq_oe), .sel_n_i(sel_n), .wen_n_i(wen_n), .oen_n_i(oen_n)
  );

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_drive(bit s_n, bit w_n, bit o_n);
    return !s_n && w_n && !o_n;
  endfunction

  task automatic do_read(int addr, bit o_n, bit scramble);
    pin_addr = AW'(addr); sel_n = 1'b1; wen_n = 1'b1; oen_n = o_n;
    idle(SETTLE);
    sel_n = 1'b0;
    idle(SETTLE);
    if (scramble) begin
      pin_addr = AW'(addr) ^ AW'($urandom_range(1, (1 << AW) - 1));
      idle(SETTLE);
    end
    chk(dq_oe == exp_drive(1'b0, 1'b1, o_n), o_n ? "R7" : "R9", "drive", dq_oe, exp_drive(1'b0, 1'b1, o_n));
    if (!o_n && model.exists(addr))
      chk(dq_o == model[addr], scramble ? "R3" : "R2", "read data", dq_o, model[addr]);
    sel_n = 1'b1;
    idle(SETTLE);
    chk(dq_oe == 1'b0, "R4", "drive in standby", dq_oe, 0);
  endtask

  task automatic do_write(int addr, logic [DW-1:0] data, bit early, bit o_n,
                          bit scramble, bit end_by_sel);
    pin_addr = AW'(addr); dq_i = ~data; sel_n = 1'b1; wen_n = !early; oen_n = o_n;
    idle(SETTLE);
    sel_n = 1'b0;
    idle(SETTLE);
    if (!early) begin
      wen_n = 1'b0;
      idle(SETTLE);
    end
    chk(dq_oe == 1'b0, "R8", "drive during write", dq_oe, 0);
    if (scramble) pin_addr = AW'(addr) ^ AW'($urandom_range(1, (1 << AW) - 1));
    dq_i = data;
    idle(SETTLE);
    if (end_by_sel) begin
      sel_n = 1'b1; idle(SETTLE); wen_n = 1'b1;
    end else begin
      wen_n = 1'b1; idle(SETTLE); sel_n = 1'b1;
    end
    idle(SETTLE);
    model[addr] = data;
  endtask

  task automatic do_standby_pulse(int addr, logic [DW-1:0] data);
    pin_addr = AW'(addr); dq_i = data; sel_n = 1'b1; oen_n = 1'b0;
    idle(2);
    wen_n = 1'b0;
    idle(SETTLE);
    chk(dq_oe == 1'b0, "R4", "drive with select high", dq_oe, 0);
    wen_n = 1'b1;
    idle(SETTLE);
  endtask

  initial begin
    void'($urandom(32'd4242));
    idle(4);
    chk(dq_oe == 1'b0, "R1", "drive in reset", dq_oe, 0);
    rst_n = 1'b1;
    idle(SETTLE);
    chk(dq_oe == 1'b0, "R1", "drive after reset", dq_oe, 0);

    // R10: both ends of the array hold independent bytes
    do_write(0, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0);
    do_write(8191, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0);
    do_read(0, 1'b0, 1'b0);
    chk(dq_o == 8'h5A, "R10", "low end byte", dq_o, 8'h5A);
    do_read(8191, 1'b0, 1'b0);
    chk(dq_o == 8'hA5, "R10", "high end byte", dq_o, 8'hA5);

    // R3: scramble after capture, on read and on write
    do_write(100, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b0);
    do_read(100, 1'b0, 1'b1);

    // R6: strobe low before select falls, closed by select rise
    do_write(200, 8'hC3, 1'b1, 1'b0, 1'b0, 1'b1);
    do_read(200, 1'b0, 1'b0);
    chk(dq_o == 8'hC3, "R6", "early write byte", dq_o, 8'hC3);

    // R5: closed by select rise with late strobe, data changed mid-write
    do_write(300, 8'h77, 1'b0, 1'b0, 1'b1, 1'b1);
    do_read(300, 1'b0, 1'b0);
    chk(dq_o == 8'h77, "R5", "last sampled byte", dq_o, 8'h77);

    // R7: gate high does not block a write, and blocks the drive
    do_write(400, 8'h99, 1'b0, 1'b1, 1'b0, 1'b0);
    do_read(400, 1'b1, 1'b0);
    do_read(400, 1'b0, 1'b0);
    chk(dq_o == 8'h99, "R7", "write with gate high", dq_o, 8'h99);

    // R4: strobe pulses in standby store nothing
    do_standby_pulse(0, 8'hEE);
    do_standby_pulse(8191, 8'h11);
    do_read(0, 1'b0, 1'b0);
    chk(dq_o == 8'h5A, "R4", "standby pulse ignored", dq_o, 8'h5A);
    do_read(8191, 1'b0, 1'b0);

    // mixed random traffic
    for (int i = 0; i < 250; i++) begin
      int a;
      int op;
      a  = (int'($urandom_range(0, 15)) * 517) % 8192;
      op = int'($urandom_range(0, 3));
      if (op == 0)
        do_read(a, 1'b0, 1'($urandom_range(0, 1)));
      else if (op == 1)
        do_standby_pulse(a, 8'($urandom));
      else
        do_write(a, 8'($urandom), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    for (int i = 0; i < 16; i++) do_read((i * 517) % 8192, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL R9 watchdog expired: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule